// File: doc/BRIEF.md
# System Control Register Bank

This block is a bank of 32-bit control words for an SoC. It sits behind a single-cycle request bus that uses byte addresses. Software writes words into the bank and reads them back. A small group of words holds identification constants after reset, and every other word resets to zero. Reads at a few fixed offsets return two status bits forced high. The word in storage does not change.

One offset, 0xF00, lies outside the backed storage and takes a power command. Writing the right code there sends a one-cycle reset-request pulse or a one-cycle shutdown-request pulse to an external power manager. Accesses beyond the backed storage are otherwise harmless. Such writes are dropped and such reads return zero.

Top module: `sys_ctrl_regs`

## Requirements
- R1: After reset, word indices 0x40, 0x41, 0x42 and 0x43 (byte offsets 0x100, 0x104, 0x108, 0x10C) hold 0x05F20121, 0x00000002, 0x05F30121 and 0x05F40121 in that order.
- R2: After reset, every other backed word (byte offsets 0x000 to 0x7FC) holds zero.
- R3: A write with word index below 512 replaces all 32 bits of the word at that index. The index is the byte offset divided by 4.
- R4: Read data appears on rdata_o in the cycle after the read strobe. The two low address bits are ignored on both reads and writes.
- R5: A write with word index 512 or more (byte offset 0x800 and up) changes no stored word. It does not alias onto a lower index.
- R6: A read with word index 512 or more returns zero.
- R7: Reads at byte offsets 0x100, 0x108 and 0x10C return the stored word ORed with 0x30000000 (bits 29 and 28 set). Other offsets, 0x104 included, return the stored word unchanged.
- R8: A write of data 1 or 2 to byte offset 0xF00 raises sys_reset_req_o for exactly one cycle, in the cycle after the write.
- R9: A write of data 3 to byte offset 0xF00 raises sys_shutdown_req_o for exactly one cycle, in the cycle after the write.
- R10: Neither request output is raised by any other data value at 0xF00 (the whole 32-bit word is compared), by reads, or by writes to other offsets. The two outputs are never high together.
- R11: A power command fires even though 0xF00 is outside storage. The command write leaves the storage untouched (for example word 0x1C0 at 0x700).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read, qualified by req_i |
| addr_i | input | 12 | Byte offset within the 4 KiB window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data, held until the next read |
| sys_reset_req_o | output | 1 | One-cycle system reset request |
| sys_shutdown_req_o | output | 1 | One-cycle system shutdown request |

## Verification
The bench tries every class of power-command data: 1, 2, 3, zero, other small values and a word that only matches in its low byte. It also sends a valid code to an offset that would alias onto 0xF00 if the index were truncated. A decoder that compared too few bits, checked the range first or latched its outputs would show a missing, extra or stretched pulse. Out-of-range writes at 0x810 and 0xFFC are each followed by a read of the low alias. A design that dropped address bit 11 would overwrite that word. Masked and unmasked neighbours are read after writing zero and all-ones, which exposes a mask on the wrong offset or a mask folded into storage. The reset constants are read back through the mask, so a design with wrong reset values or a missing mask fails there.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam logic [31:0] STATUS_FORCE = 32'h3000_0000;
  localparam int unsigned CMD_WORD = 'h3C0;    // byte 0xF00 >> 2

  typedef enum logic [1:0] {PWR_NONE, PWR_RESET, PWR_SHUTDOWN} pwr_cmd_e;

  function automatic logic [31:0] reset_word(int unsigned idx);
    case (idx)
      'h40:    return 32'h05F2_0121;
      'h41:    return 32'h0000_0002;
      'h42:    return 32'h05F3_0121;
      'h43:    return 32'h05F4_0121;
      default: return '0;
    endcase
  endfunction

  function automatic logic status_masked(int unsigned idx);
    return (idx == 'h40) || (idx == 'h42) || (idx == 'h43);
  endfunction

  function automatic pwr_cmd_e decode_cmd(logic [31:0] data);
    if (data == 32'd1 || data == 32'd2) return PWR_RESET;
    if (data == 32'd3)                  return PWR_SHUTDOWN;
    return PWR_NONE;
  endfunction
endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode
  import sysreg_pkg::*;
#(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              reset_req_o,
  output logic              shutdown_req_o
);
  pwr_cmd_e cmd;
  logic     hit;

  assign hit = wr_i && (32'(idx_i) == CMD_WORD);
  assign cmd = hit ? decode_cmd(32'(data_i)) : PWR_NONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reset_req_o    <= 1'b0;
      shutdown_req_o <= 1'b0;
    end else begin
      reset_req_o    <= (cmd == PWR_RESET);
      shutdown_req_o <= (cmd == PWR_SHUTDOWN);
    end
  end

  p_reset_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> $past(wr_i && 32'(idx_i) == CMD_WORD &&
                          (data_i == DATA_W'(1) || data_i == DATA_W'(2))));
  p_shutdown_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_req_o |-> $past(wr_i && 32'(idx_i) == CMD_WORD && data_i == DATA_W'(3)));
  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reset_req_o && shutdown_req_o));
endmodule

// File: rtl/reg_store.sv
module reg_store
  import sysreg_pkg::*;
#(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SIDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SIDX_W-1:0] wr_idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [SIDX_W-1:0] rd_idx_i,
  output logic [DATA_W-1:0] rd_word_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= DATA_W'(reset_word(i));
    end else if (wr_i) begin
      mem_q[wr_idx_i] <= wdata_i;
    end
  end

  assign rd_word_o = mem_q[rd_idx_i];
endmodule

// File: rtl/read_shaper.sv
module read_shaper
  import sysreg_pkg::*;
#(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              in_range_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] word_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] force_bits;

  assign force_bits = status_masked(32'(idx_i)) ? DATA_W'(STATUS_FORCE) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= in_range_i ? (word_i | force_bits) : '0;
  end

  p_oob_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && !in_range_i) |-> rdata_o == '0);
  p_force_bits_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_i && in_range_i && (32'(idx_i) == 'h40 || 32'(idx_i) == 'h42 ||
                                 32'(idx_i) == 'h43)) |-> rdata_o[29:28] == 2'b11);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rd_i) |-> $stable(rdata_o));
endmodule

// File: rtl/sys_ctrl_regs.sv
module sys_ctrl_regs #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 512
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sys_reset_req_o,
  output logic              sys_shutdown_req_o
);
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned SIDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0]  word_idx;
  logic              in_range, wr, rd;
  logic [DATA_W-1:0] stored;

  assign word_idx = addr_i[ADDR_W-1:2];
  assign in_range = 32'(word_idx) < DEPTH;
  assign wr       = req_i && we_i;
  assign rd       = req_i && !we_i;

  pwr_cmd_decode #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_cmd (
    .clk_i, .rst_ni, .wr_i(wr), .idx_i(word_idx), .data_i(wdata_i),
    .reset_req_o(sys_reset_req_o), .shutdown_req_o(sys_shutdown_req_o)
  );

  reg_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni, .wr_i(wr && in_range),
    .wr_idx_i(word_idx[SIDX_W-1:0]), .wdata_i(wdata_i),
    .rd_idx_i(word_idx[SIDX_W-1:0]), .rd_word_o(stored)
  );

  read_shaper #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rd (
    .clk_i, .rst_ni, .rd_i(rd), .in_range_i(in_range),
    .idx_i(word_idx), .word_i(stored), .rdata_o(rdata_o)
  );

  p_pulse_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_reset_req_o && !$past(wr)) |=> !sys_reset_req_o);
  p_no_cmd_on_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!wr) |-> !(sys_reset_req_o || sys_shutdown_req_o));
endmodule

// File: tb/sys_ctrl_regs_test.sv
module sys_ctrl_regs_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        sys_reset_req_o, sys_shutdown_req_o;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  sys_ctrl_regs uut (
    .clk_i(clk), .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .sys_reset_req_o, .sys_shutdown_req_o
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk); req_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk); req_i = 0; d = rdata_o;
  endtask

  task automatic t_reset_values;
    logic [31:0] d;
    check("R10 idle reset_req", {31'b0, sys_reset_req_o}, 0);
    check("R10 idle shutdown_req", {31'b0, sys_shutdown_req_o}, 0);
    rd(12'h100, d); check("R1 0x100", d, 32'h35F2_0121);
    rd(12'h104, d); check("R1 0x104", d, 32'h0000_0002);
    rd(12'h108, d); check("R1 0x108", d, 32'h35F3_0121);
    rd(12'h10C, d); check("R1 0x10C", d, 32'h35F4_0121);
    rd(12'h000, d); check("R2 0x000", d, 0);
    rd(12'h7FC, d); check("R2 0x7FC", d, 0);
    rd(12'h700, d); check("R2 0x700", d, 0);
  endtask

  task automatic t_cmd(logic [11:0] a, logic [31:0] d, bit exp_r, bit exp_s, string tag);
    @(negedge clk); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk); req_i = 0; we_i = 0;
    check({tag, " reset pulse"}, {31'b0, sys_reset_req_o}, {31'b0, exp_r});
    check({tag, " shutdown pulse"}, {31'b0, sys_shutdown_req_o}, {31'b0, exp_s});
    @(negedge clk);
    check({tag, " reset single cycle"}, {31'b0, sys_reset_req_o}, 0);
    check({tag, " shutdown single cycle"}, {31'b0, sys_shutdown_req_o}, 0);
  endtask

  task automatic t_commands;
    logic [31:0] d;
    t_cmd(12'hF00, 32'd1, 1, 0, "R8 data1");
    t_cmd(12'hF00, 32'd2, 1, 0, "R8 data2");
    t_cmd(12'hF00, 32'd3, 0, 1, "R9 data3");
    t_cmd(12'hF00, 32'd0, 0, 0, "R10 data0");
    t_cmd(12'hF00, 32'd4, 0, 0, "R10 data4");
    t_cmd(12'hF00, 32'h0000_0101, 0, 0, "R10 data0x101");
    t_cmd(12'h700, 32'd1, 0, 0, "R10 alias 0x700");
    t_cmd(12'hF02, 32'd3, 0, 1, "R11 low bits ignored");
    rd(12'h700, d); check("R11 storage untouched 0x700", d, 32'd1);
  endtask

  task automatic t_write_read;
    logic [31:0] d;
    wr(12'h010, 32'hA5A5_5A5A); rd(12'h010, d); check("R3 write 0x010", d, 32'hA5A5_5A5A);
    wr(12'h010, 32'h1234_5678); rd(12'h010, d); check("R3 overwrite", d, 32'h1234_5678);
    wr(12'h7FC, 32'hDEAD_BEEF); rd(12'h7FC, d); check("R3 last word", d, 32'hDEAD_BEEF);
    wr(12'h020, 32'h0BAD_F00D); rd(12'h023, d); check("R4 read low bits", d, 32'h0BAD_F00D);
    wr(12'h031, 32'hCAFE_0001); rd(12'h030, d); check("R4 write low bits", d, 32'hCAFE_0001);
    rd(12'h7FC, d); check("R4 rdata after read", d, 32'hDEAD_BEEF);
    repeat (2) @(negedge clk);
    check("R4 rdata held", rdata_o, 32'hDEAD_BEEF);
  endtask

  task automatic t_out_of_range;
    logic [31:0] d;
    wr(12'h810, 32'hFFFF_FFFF); rd(12'h010, d); check("R5 0x810 dropped", d, 32'h1234_5678);
    wr(12'hFFC, 32'h0000_0055); rd(12'h7FC, d); check("R5 0xFFC dropped", d, 32'hDEAD_BEEF);
    rd(12'h810, d); check("R6 read 0x810", d, 0);
    rd(12'hF00, d); check("R6 read 0xF00", d, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(12'h108, 32'h0);          rd(12'h108, d); check("R7 0x108 zero", d, 32'h3000_0000);
    wr(12'h100, 32'hFFFF_FFFF);  rd(12'h100, d); check("R7 0x100 ones", d, 32'hFFFF_FFFF);
    wr(12'h10C, 32'h0000_1234);  rd(12'h10C, d); check("R7 0x10C", d, 32'h3000_1234);
    wr(12'h104, 32'h0);          rd(12'h104, d); check("R7 0x104 unmasked", d, 0);
    wr(12'h110, 32'h0);          rd(12'h110, d); check("R7 0x110 unmasked", d, 0);
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset_values();
    t_commands();
    t_write_read();
    t_out_of_range();
    t_mask();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule